// File: doc/BRIEF.md
# Multiplexed Address/Data Register Bus Slave

This block sits inside an FPGA and answers a host processor that reaches it over one shared 16-bit bus. The host uses three active-high strobes to pick what each bus phase means. In the first phase it puts a register address on the bus and pulses the address strobe. In the second phase it either puts a data word on the bus and pulses the write strobe, or it lets go of the bus and holds the read strobe high while the slave drives the selected register back.

The host's strobes have no timing relation to the FPGA clock. Each strobe therefore passes through a two-flop synchronizer and an edge detector. The address and write actions fire once, on the synchronized rising edge. The read strobe is used as a synchronized level that opens the output drivers.

The register map has four fixed, read-only words and one general read/write register:
- A version word that packs a BCD release number.
- Three application identity words.
- The general read/write register, which sits at a separate address.

An active-low reset clears the address register, the general register and the synchronizers.

Top module: `mbus_slave`

## Requirements
- R1: After `rst_n` goes low, the latched address and the general register are 0x0000 and `bus_oe` is low. A read with no address phase after reset therefore returns 0x0000.
- R2: One address-strobe pulse loads `bus_in` into the address register. The address then stays in place through any number of reads and writes until the next address-strobe pulse.
- R3: A write-strobe pulse while the address is 0x8000 stores `bus_in` in the general register. Later reads at 0x8000 return that value unchanged.
- R4: Address 0x0004 reads the version word 0x0070. Bits 15:8 hold the major release in BCD (00), bits 7:4 the minor release in BCD (7), and bits 3:0 the sub-minor release in BCD (0).
- R5: Addresses 0x0005, 0x0006 and 0x0007 read the fixed identity words 0xA5C1, 0x0B2E and 0x3F90.
- R6: A write to any address other than 0x8000 has no effect. The general register and the fixed words read back as they were before the write.
- R7: A read at any address outside 0x0004 to 0x0007 and other than 0x8000 returns 0x0000.
- R8: `bus_oe` goes high on the second clock edge after `rd_stb` rises. It goes low on the second clock edge after `rd_stb` falls. While `bus_oe` is low, `bus_out` is 0x0000.
- R9: A write strobe that stays high for many cycles stores only once, taking the bus value present at its synchronized rising edge. Later changes on the bus while the strobe is still high are not stored.
- R10: When the address strobe and the write strobe rise in the same cycle, the write goes to the address that was latched before. The new address takes effect only for later transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Value the host drives on the shared bus |
| addr_stb | input | 1 | Host strobe: latch an address (asynchronous) |
| wr_stb | input | 1 | Host strobe: write data (asynchronous) |
| rd_stb | input | 1 | Host strobe: read data, level-sensitive (asynchronous) |
| bus_out | output | 16 | Read data for the shared bus; 0 when not driving |
| bus_oe | output | 1 | Tri-state enable for the bus pads |

## Verification
The address latch and the data write can fire on the same clock edge when the host raises both strobes together. The bench provokes this twice:
- With 0x8000 already latched and a fresh value on the bus, raising both strobes must land the value in the general register and leave that value as the new address, which then reads back as 0x0000 because nothing is mapped there.
- With 0x0006 latched and 0x8000 on the bus, the write must be dropped and the general register must keep its old value, which a read after the address change confirms.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned BUS_W = 16;
  typedef logic [BUS_W-1:0] word_t;

  typedef enum logic [1:0] {
    STB_ADDR = 2'd0,
    STB_WR   = 2'd1,
    STB_RD   = 2'd2
  } stb_idx_e;

  localparam int unsigned NUM_STB = 3;

  function automatic word_t bcd_version(input logic [7:0] major,
                                        input logic [3:0] minor,
                                        input logic [3:0] patch);
    return {major, minor, patch};
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
#(
  parameter word_t VERSION  = 16'h0070,
  parameter word_t APP_ID0  = 16'hA5C1,
  parameter word_t APP_ID1  = 16'h0B2E,
  parameter word_t APP_ID2  = 16'h3F90,
  parameter word_t VER_ADDR = 16'h0004,
  parameter word_t GP_ADDR  = 16'h8000
) (
  input  word_t addr,
  input  word_t gp_val,
  output word_t rd_data,
  output logic  gp_sel
);
  localparam int unsigned NUM_FIXED = 4;

  word_t fixed_w [NUM_FIXED];
  assign fixed_w[0] = VERSION;
  assign fixed_w[1] = APP_ID0;
  assign fixed_w[2] = APP_ID1;
  assign fixed_w[3] = APP_ID2;

  logic [NUM_FIXED-1:0] fixed_hit;

  genvar g;
  generate
    for (g = 0; g < NUM_FIXED; g++) begin : g_fixed
      assign fixed_hit[g] = (addr == VER_ADDR + word_t'(g));
    end
  endgenerate

  assign gp_sel = (addr == GP_ADDR);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FIXED; i++) begin
      if (fixed_hit[i]) rd_data = fixed_w[i];
    end
    if (gp_sel) rd_data = gp_val;
  end
endmodule

// File: rtl/mbus_regs.sv
module mbus_regs
  import mbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t bus_in,
  input  logic  addr_fire,
  input  logic  wr_fire,
  input  logic  gp_sel,
  output word_t addr_q,
  output word_t gp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_fire) addr_q <= bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gp_q <= '0;
    else if (wr_fire && gp_sel) gp_q <= bus_in;
  end
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
  import mbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter word_t VERSION = 16'h0070,
  parameter word_t APP_ID0 = 16'hA5C1,
  parameter word_t APP_ID1 = 16'h0B2E,
  parameter word_t APP_ID2 = 16'h3F90,
  parameter word_t GP_ADDR = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_in,
  input  logic        addr_stb,
  input  logic        wr_stb,
  input  logic        rd_stb,
  output logic [15:0] bus_out,
  output logic        bus_oe
);
  logic [NUM_STB-1:0] raw_stb, stb_level, stb_rise;
  word_t addr_q, gp_q, rd_data;
  logic  gp_sel;
  logic  addr_fire, wr_fire;

  assign raw_stb[STB_ADDR] = addr_stb;
  assign raw_stb[STB_WR]   = wr_stb;
  assign raw_stb[STB_RD]   = rd_stb;

  genvar g;
  generate
    for (g = 0; g < NUM_STB; g++) begin : g_sync
      strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_stb[g]),
        .level(stb_level[g]),
        .rise (stb_rise[g])
      );
    end
  endgenerate

  assign addr_fire = stb_rise[STB_ADDR];
  assign wr_fire   = stb_rise[STB_WR];

  mbus_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (bus_in),
    .addr_fire(addr_fire),
    .wr_fire  (wr_fire),
    .gp_sel   (gp_sel),
    .addr_q   (addr_q),
    .gp_q     (gp_q)
  );

  mbus_decode #(
    .VERSION(VERSION), .APP_ID0(APP_ID0), .APP_ID1(APP_ID1),
    .APP_ID2(APP_ID2), .GP_ADDR(GP_ADDR)
  ) u_dec (
    .addr   (addr_q),
    .gp_val (gp_q),
    .rd_data(rd_data),
    .gp_sel (gp_sel)
  );

  assign bus_oe  = stb_level[STB_RD];
  assign bus_out = bus_oe ? rd_data : '0;
endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb,
  input logic        bus_oe,
  input logic [15:0] bus_out,
  input logic [15:0] addr_q,
  input logic [15:0] gp_q,
  input logic        addr_fire,
  input logic        wr_fire
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(!rst_n) |-> (addr_q == 16'h0 && gp_q == 16'h0 && !bus_oe)); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_fire |=> $stable(addr_q)); // R2

  AST_GP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(gp_q)); // R6

  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && addr_q == 16'h0004) |-> bus_out == 16'h0070); // R4

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb, 2) |-> !bus_oe); // R8

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == 16'h0); // R8

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire); // R9
endmodule

bind mbus_slave mbus_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_stb   (rd_stb),
  .bus_oe   (bus_oe),
  .bus_out  (bus_out),
  .addr_q   (addr_q),
  .gp_q     (gp_q),
  .addr_fire(addr_fire),
  .wr_fire  (wr_fire)
);

// File: tb/sim_mbus_slave.sv
`timescale 1ns/1ps
module sim_mbus_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_in = 16'h0;
  logic        addr_stb = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [15:0] bus_out;
  logic        bus_oe;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        oe_prev = 1'b0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  mbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .addr_stb(addr_stb), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [15:0] a);
    bus_in = a; addr_stb = 1'b1; cyc(4);
    addr_stb = 1'b0; cyc(4);
  endtask

  task automatic wr_data(input logic [15:0] d);
    bus_in = d; wr_stb = 1'b1; cyc(4);
    wr_stb = 1'b0; cyc(4);
  endtask

  task automatic rd_expect(input string tag, input logic [15:0] exp);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_in = 16'h0; rd_stb = 1'b1; cyc(4);
    rd_stb = 1'b0; cyc(4);
  endtask

  // monitor: compare on the first sample of each read window
  always @(negedge clk) begin
    if (rst_n && bus_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8: unexpected output enable, actual %h expected none", bus_out);
      end else begin
        check(tag_q.pop_front(), bus_out, exp_q.pop_front());
      end
    end
    oe_prev = bus_oe;
  end

  initial begin
    cyc(3);
    check("R1 oe after reset", {15'h0, bus_oe}, 16'h0);
    check("R1 bus_out after reset", bus_out, 16'h0);
    rst_n = 1'b1; cyc(2);
    rd_expect("R1 read without address", 16'h0000);

    set_addr(16'h0004);
    rd_expect("R4 version word", 16'h0070);
    rd_expect("R2 repeat read same address", 16'h0070);
    set_addr(16'h0005); rd_expect("R5 id0", 16'hA5C1);
    set_addr(16'h0006); rd_expect("R5 id1", 16'h0B2E);
    set_addr(16'h0007); rd_expect("R5 id2", 16'h3F90);

    set_addr(16'h8000); wr_data(16'h1234);
    rd_expect("R3 readback 1234", 16'h1234);
    wr_data(16'hBEEF);
    rd_expect("R3 readback beef", 16'hBEEF);
    rd_expect("R2 persist after write", 16'hBEEF);

    set_addr(16'h0005); wr_data(16'hFFFF);
    rd_expect("R6 id0 unchanged", 16'hA5C1);
    set_addr(16'h1234); wr_data(16'h5555);
    rd_expect("R7 unmapped 1234", 16'h0000);
    set_addr(16'h8001); rd_expect("R7 unmapped 8001", 16'h0000);
    set_addr(16'h8000); rd_expect("R6 gp unchanged", 16'hBEEF);

    // R8 enable timing, exact edges
    exp_q.push_back(16'hBEEF); tag_q.push_back("R8 data in window");
    rd_stb = 1'b1; cyc(1);
    check("R8 oe low after one edge", {15'h0, bus_oe}, 16'h0);
    cyc(1);
    check("R8 oe high after two edges", {15'h0, bus_oe}, 16'h1);
    cyc(2); rd_stb = 1'b0; cyc(1);
    check("R8 oe still high one edge after fall", {15'h0, bus_oe}, 16'h1);
    cyc(1);
    check("R8 oe low two edges after fall", {15'h0, bus_oe}, 16'h0);
    check("R8 bus quiet", bus_out, 16'h0);
    cyc(3);

    // R9 long strobe, bus changes mid-pulse
    bus_in = 16'h0F0F; wr_stb = 1'b1; cyc(6);
    bus_in = 16'hF0F0; cyc(6);
    wr_stb = 1'b0; cyc(4);
    rd_expect("R9 single capture", 16'h0F0F);

    // R10 simultaneous address latch and write
    bus_in = 16'h7777; addr_stb = 1'b1; wr_stb = 1'b1; cyc(4);
    addr_stb = 1'b0; wr_stb = 1'b0; cyc(4);
    rd_expect("R10 new address unmapped", 16'h0000);
    set_addr(16'h8000); rd_expect("R10 write used old address", 16'h7777);
    set_addr(16'h0006);
    bus_in = 16'h8000; addr_stb = 1'b1; wr_stb = 1'b1; cyc(4);
    addr_stb = 1'b0; wr_stb = 1'b0; cyc(4);
    rd_expect("R10 write to id dropped", 16'h7777);

    // R1 reset mid-operation
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    rd_expect("R1 address cleared", 16'h0000);
    set_addr(16'h8000); rd_expect("R1 gp cleared", 16'h0000);

    cyc(4);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: %0d reads never enabled, actual %0d expected 0", exp_q.size(), exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule